// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a local countdown timer for a processor's interrupt front end. Software programs three registers and one timer entry through a simple register port. The entry holds an interrupt vector, a mask bit and a mode bit. The divide register selects how fast the count moves: the input clock is divided by a power of two, from 1 up to 128. The initial-count register loads the counter and restarts timing. The current-count register can be read back at any moment.

In one-shot mode the counter steps down once per divided tick and stops at zero. It raises a single expiry as it arrives there. In periodic mode the counter wraps from zero back to the initial value, so each period lasts one tick longer than the initial count. Every wrap raises an expiry. An expiry that is not masked appears as a one-cycle vector strobe carrying the entry's vector, and a downstream priority controller takes it from there. An initial count of zero keeps the timer idle.

Register map (selected by a 2-bit address): 0 is the timer entry, 1 is the initial count, 2 is the current count (read-only), and 3 is the divide configuration. Writes take effect at the clock edge on which the write enable is sampled. All registers are cleared by a synchronous active-high reset, except that the mask bit of the entry resets to 1.

Top module: `tick_timer`

## Requirements
- R1: A write to the divide register (address 3) keeps only bits 0, 1 and 3 (mask 0xB). Reading address 3 returns the stored value, so writing 0xFFFFFFFF reads back 0xB.
- R2: The divisor is 2 to the power s. A 3-bit code is built with divide bit 3 as its top bit and divide bits 1:0 as its low bits, and s = (code + 1) mod 8. Examples: 0xB gives 1, 0x0 gives 2, 0x3 gives 16, 0x8 gives 32 and 0xA gives 128.
- R3: Writing N to the initial count (address 1) sets the current count to N at that edge and restarts the divider. With divisor D, the first decrement lands D edges after the write edge.
- R4: In one-shot mode (entry bit 17 = 0), the count stops at zero and a single expiry occurs N*D edges after the write edge. After that, the current count (address 2) reads 0 until the next initial-count write.
- R5: In periodic mode (entry bit 17 = 1), the count reloads N on the tick after it reaches zero. Expiries come every (N+1)*D edges, and the first one falls (N+1)*D edges after the write edge.
- R6: When entry bit 16 (mask) is 1, expiries produce no strobe, but counting continues.
- R7: An unmasked expiry drives irqStrobe high for exactly one cycle. On that cycle irqVector equals entry bits 7:0. The strobe appears on the edge where the count takes its post-expiry value.
- R8: A write to the entry changes the running state from the next cycle. A one-shot timer that is parked at zero and is switched to periodic wraps on the next tick and then keeps running with period N+1.
- R9: While the initial count is zero the timer is stopped and no strobe occurs. Writing 0 stops a running periodic timer and sets the current count to 0.
- R10: Writes to the current-count address (2) have no effect on the count.
- R11: An initial-count write that falls on the same cycle as an expiry tick takes priority. That expiry produces no strobe, and the count takes the written value.
- R12: After reset the entry reads 0x00010000 (masked, vector 0, one-shot). The initial count, current count and divide register read 0, and irqStrobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 2 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 32 | Read data for rdAddr (combinational) |
| irqStrobe | output | 1 | One-cycle expiry strobe |
| irqVector | output | 8 | Vector accompanying irqStrobe |

## Verification
The two functions that can land in the same cycle are a periodic wrap expiry and a software reload of the initial count. The bench runs a periodic timer with a period of four divided-by-one ticks. It times an initial-count write so that the write commits on the very edge at which the wrap would strobe. The scoreboard expects no strobe on that edge and a new strobe one full period after the write, and a direct read confirms the count holds the written value.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  parameter int CNT_W   = 32;
  parameter int VEC_W   = 8;
  parameter int SHIFT_W = 3;
  parameter int ADDR_W  = 2;
  localparam int PRE_W  = (1 << SHIFT_W) - 1;
  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;
  localparam logic [3:0] DIV_KEEP = 4'b1011;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENTRY = 2'd0,
    REG_INIT  = 2'd1,
    REG_CUR   = 2'd2,
    REG_DIV   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             load;
    logic             tick;
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
    logic [CNT_W-1:0] loadVal;
    logic [CNT_W-1:0] reload;
  } ctl_s;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CNT_W-1:0]  curCount,
  output logic [CNT_W-1:0]  rdData,
  output ctl_s              ctl
);
  logic [VEC_W-1:0]   vecReg;
  logic               maskReg;
  logic               modeReg;
  logic [CNT_W-1:0]   initReg;
  logic [3:0]         divReg;
  logic [PRE_W-1:0]   preCnt;
  logic [SHIFT_W-1:0] divCode;
  logic [SHIFT_W-1:0] shiftAmt;
  logic [PRE_W-1:0]   divMask;
  logic               wrEntry, wrInit, wrDiv;

  assign wrEntry = wrEn && (wrAddr == REG_ENTRY);
  assign wrInit  = wrEn && (wrAddr == REG_INIT);
  assign wrDiv   = wrEn && (wrAddr == REG_DIV);

  // split divide code: stored bit 3 on top, bits 1:0 below
  assign divCode  = {divReg[3], divReg[1:0]};
  assign shiftAmt = divCode + SHIFT_W'(1);

  // low-order ones mask selecting how many prescaler bits must be set
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign divMask[i] = (SHIFT_W'(i) < shiftAmt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vecReg  <= '0;
      maskReg <= 1'b1;
      modeReg <= 1'b0;
      initReg <= '0;
      divReg  <= '0;
      preCnt  <= '0;
    end else begin
      if (wrEntry) begin
        vecReg  <= wrData[VEC_W-1:0];
        maskReg <= wrData[MASK_BIT];
        modeReg <= wrData[MODE_BIT];
      end
      if (wrInit) initReg <= wrData;
      if (wrDiv)  divReg  <= wrData[3:0] & DIV_KEEP;
      preCnt <= wrInit ? '0 : preCnt + PRE_W'(1);
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.load     = wrInit;
    ctl.loadVal  = wrData;
    ctl.tick     = (preCnt & divMask) == divMask;
    ctl.periodic = modeReg;
    ctl.masked   = maskReg;
    ctl.vector   = vecReg;
    ctl.reload   = initReg;
  end

  always_comb begin
    rdData = '0;
    unique case (reg_sel_e'(rdAddr))
      REG_ENTRY: begin
        rdData[VEC_W-1:0] = vecReg;
        rdData[MASK_BIT]  = maskReg;
        rdData[MODE_BIT]  = modeReg;
      end
      REG_INIT:  rdData = initReg;
      REG_CUR:   rdData = curCount;
      REG_DIV:   rdData[3:0] = divReg;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctl_s             ctl,
  output logic [CNT_W-1:0] curCount,
  output logic             irqStrobe,
  output logic [VEC_W-1:0] irqVector
);
  logic             atZero, atOne, running, expire;
  logic [CNT_W-1:0] nextCount;

  assign atZero  = (curCount == '0);
  assign atOne   = (curCount == CNT_W'(1));
  assign running = (ctl.reload != '0) && (ctl.periodic || !atZero);

  always_comb begin
    nextCount = curCount;
    expire    = 1'b0;
    if (ctl.load) begin
      nextCount = ctl.loadVal;
    end else if (ctl.tick && running) begin
      if (atZero) begin
        nextCount = ctl.reload;
        expire    = 1'b1;
      end else begin
        nextCount = curCount - CNT_W'(1);
        expire    = atOne && !ctl.periodic;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curCount  <= '0;
      irqStrobe <= 1'b0;
      irqVector <= '0;
    end else begin
      curCount  <= nextCount;
      irqStrobe <= expire && !ctl.masked;
      if (expire && !ctl.masked) irqVector <= ctl.vector;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        irqStrobe,
  output logic [7:0]  irqVector
);
  ctl_s             ctlBus;
  logic [CNT_W-1:0] curCount;

  tick_timer_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .curCount (curCount),
    .rdData   (rdData),
    .ctl      (ctlBus)
  );

  tick_timer_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctlBus),
    .curCount  (curCount),
    .irqStrobe (irqStrobe),
    .irqVector (irqVector)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [1:0]       rdAddr,
  input logic [31:0]      rdData,
  input logic             irqStrobe,
  input logic [7:0]       irqVector,
  input ctl_s             ctl,
  input logic [CNT_W-1:0] curCount
);
  p_div_keep_r1: assert property (@(posedge clk) disable iff (rst)
    (rdAddr == REG_DIV) |-> (rdData[31:4] == '0 && rdData[2] == 1'b0));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (curCount == $past(ctl.loadVal)));

  p_oneshot_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl.load && !ctl.periodic && curCount == '0) |=> (curCount == '0));

  p_mask_r6: assert property (@(posedge clk) disable iff (rst)
    irqStrobe |-> !$past(ctl.masked));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    irqStrobe |=> !irqStrobe);

  p_vector_r7: assert property (@(posedge clk) disable iff (rst)
    irqStrobe |-> (irqVector == $past(ctl.vector)));

  p_zero_init_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl.reload == '0) |=> !irqStrobe);

  p_collide_r11: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> !irqStrobe);
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rdAddr    (rdAddr),
  .rdData    (rdData),
  .irqStrobe (irqStrobe),
  .irqVector (irqVector),
  .ctl       (ctlBus),
  .curCount  (curCount)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irqStrobe;
  logic [7:0]  irqVector;

  int unsigned edgeCount = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { int unsigned at; logic [7:0] vec; string req; } exp_t;
  exp_t expQ[$];

  localparam logic [1:0] A_ENTRY = 2'd0, A_INIT = 2'd1, A_CUR = 2'd2, A_DIV = 2'd3;

  tick_timer u_tick_timer (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqStrobe(irqStrobe), .irqVector(irqVector)
  );

  always #5 clk = ~clk;
  always @(posedge clk) edgeCount <= edgeCount + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at edge %0d", req, act, exp, edgeCount);
    end
  endtask

  // called right after a falling edge; returns after the commit edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int unsigned commit);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    commit = edgeCount;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic waitUntil(input int unsigned t);
    while (edgeCount < t) @(negedge clk);
  endtask

  task automatic expect_at(input int unsigned t, input logic [7:0] v, input string req);
    exp_t e;
    e.at = t; e.vec = v; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: every strobe must match the head of the scoreboard queue
  always @(negedge clk) begin
    if (!rst && irqStrobe) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 unexpected strobe actual=edge %0d vec %h expected=none", edgeCount, irqVector);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk({e.req, " strobe edge"}, 32'(edgeCount), 32'(e.at));
        chk({e.req, " strobe vector (R7)"}, 32'(irqVector), 32'(e.vec));
      end
    end else if (!rst && expQ.size() != 0 && edgeCount > expQ[0].at) begin
      exp_t e;
      e = expQ.pop_front();
      checks++; fails++;
      $display("FAIL %s missing strobe actual=none expected=edge %0d", e.req, e.at);
    end
  end

  initial begin
    int unsigned c, w;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    rd(A_ENTRY, v); chk("R12 entry", v, 32'h0001_0000);
    rd(A_INIT, v);  chk("R12 init", v, 0);
    rd(A_CUR, v);   chk("R12 cur", v, 0);
    rd(A_DIV, v);   chk("R12 div", v, 0);
    chk("R12 strobe low", 32'(irqStrobe), 0);

    // R1 divide field masking
    wr(A_DIV, 32'hFFFF_FFFF, c);
    rd(A_DIV, v); chk("R1 div keep 0xB", v, 32'hB);

    // R4/R3/R10 one-shot, divide by one
    wr(A_ENTRY, 32'h0000_0041, c);
    wr(A_INIT, 5, c);
    rd(A_CUR, v); chk("R3 loaded count", v, 5);
    expect_at(c + 5, 8'h41, "R4");
    waitUntil(c + 7);
    rd(A_CUR, v); chk("R4 count parked at zero", v, 0);
    wr(A_CUR, 32'h1234, w);
    rd(A_CUR, v); chk("R10 current count write ignored", v, 0);
    waitUntil(c + 12);

    // R2 divide by two
    wr(A_DIV, 32'h0, c);
    wr(A_INIT, 4, c);
    expect_at(c + 8, 8'h41, "R2 div2");
    waitUntil(c + 10);

    // R2/R3 divide by sixteen, first decrement after D edges
    wr(A_DIV, 32'h3, c);
    wr(A_INIT, 3, c);
    expect_at(c + 48, 8'h41, "R2 div16");
    waitUntil(c + 15);
    rd(A_CUR, v); chk("R3 no decrement before D edges", v, 3);
    waitUntil(c + 16);
    rd(A_CUR, v); chk("R3 first decrement at D edges", v, 2);
    waitUntil(c + 50);

    // R2 divide by thirty-two
    wr(A_DIV, 32'h8, c);
    wr(A_INIT, 1, c);
    expect_at(c + 32, 8'h41, "R2 div32");
    waitUntil(c + 34);

    // R2 divide by one hundred twenty-eight
    wr(A_DIV, 32'hA, c);
    wr(A_INIT, 2, c);
    expect_at(c + 256, 8'h41, "R2 div128");
    waitUntil(c + 258);

    // R5 periodic, then R9 stop with zero
    wr(A_DIV, 32'hB, c);
    wr(A_ENTRY, 32'h0002_0055, c);
    wr(A_INIT, 3, c);
    expect_at(c + 4, 8'h55, "R5");
    expect_at(c + 8, 8'h55, "R5");
    expect_at(c + 12, 8'h55, "R5");
    waitUntil(c + 13);
    wr(A_INIT, 0, w);
    waitUntil(w + 20);
    rd(A_CUR, v); chk("R9 stopped count", v, 0);
    rd(A_INIT, v); chk("R9 init zero", v, 0);

    // R6 masked one-shot still counts
    wr(A_ENTRY, 32'h0001_0022, c);
    wr(A_INIT, 3, c);
    rd(A_CUR, v); chk("R6 masked load", v, 3);
    waitUntil(c + 10);
    rd(A_CUR, v); chk("R6 masked count reached zero", v, 0);

    // R8 one-shot parked at zero switched to periodic
    wr(A_ENTRY, 32'h0000_0060, c);
    wr(A_INIT, 2, c);
    expect_at(c + 2, 8'h60, "R8 one-shot");
    waitUntil(c + 4);
    wr(A_ENTRY, 32'h0002_0061, w);
    expect_at(w + 1, 8'h61, "R8 resume wrap");
    expect_at(w + 4, 8'h61, "R8 period");
    waitUntil(w + 5);
    wr(A_INIT, 0, c);
    waitUntil(c + 10);

    // R11 reload colliding with a wrap
    wr(A_ENTRY, 32'h0002_0070, c);
    wr(A_INIT, 3, c);
    expect_at(c + 4, 8'h70, "R11 first wrap");
    waitUntil(c + 7);
    wr(A_INIT, 3, w);
    chk("R11 no strobe on collision", 32'(irqStrobe), 0);
    rd(A_CUR, v); chk("R11 count takes written value", v, 3);
    expect_at(w + 4, 8'h70, "R11 restarted period");
    waitUntil(w + 5);
    wr(A_INIT, 0, c);
    waitUntil(c + 10);

    chk("R5 scoreboard drained", 32'(expQ.size()), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule